// File: doc/BRIEF.md
# ECAM Configuration Access Router

This block sits behind the memory-mapped configuration window of a PCIe root complex that owns a contiguous range of bus numbers. Each request carries a byte offset into that window. The block splits the offset into bus, device/function and register fields. It then picks exactly one target:

- the Type 1 configuration space of one of the root ports on the first bus;
- an integrated endpoint that sits directly on the first bus;
- a forwarding path below a root port, tagged with the bus and device/function.

A request that matches none of these is marked unroutable. An unroutable read carries the all-ones fill value.

A 32-slot table records what occupies each device number on the first bus: nothing, a root port, or an integrated endpoint. Registration requests load the table.

- Root ports are placed one after another, starting at a configurable device number. The lower numbers stay free for endpoints.
- Each root port placement returns its interrupt requester device/function and its hotplug slot number.
- Endpoint and downstream-device attachments are checked for conflicts. A rejected attachment reports the identifier of the current occupant.

The secondary-to-subordinate bus range of each root port comes in from that port's configuration logic. The router searches these ranges to route any bus above the first.

Top module: `ecam_cfg_router`

## Requirements
- R1: `cfg_err` is high exactly when `cfg_end_bus` < `cfg_start_bus`, or when `cfg_win_mib` (window size in MiB, 1 MiB per bus) differs from `cfg_end_bus` − `cfg_start_bus` + 1.
- R2: An access strobed with `acc_valid` produces `rt_valid` on the next cycle. At that point:
  - `rt_bus` = `cfg_start_bus` + `acc_addr[27:20]`;
  - `rt_devfn` = `acc_addr[19:12]`;
  - `rt_reg` = `acc_addr[11:0]`;
  - `rt_sel` is one-hot (bit0 root port config, bit1 integrated endpoint, bit2 forward, bit3 unroutable).

  `rt_sel` is zero in cycles without a result.
- R3: On the first bus (`acc_addr[27:20]` = 0), function 0 of a slot holding a root port selects bit0. `rt_port` is set to that port's index (device number − `cfg_first_dev`).
- R4: On the first bus, function 0 of a slot holding an integrated endpoint selects bit1.
- R5: On the first bus, any nonzero function (`devfn[2:0]` ≠ 0), or any access to an empty slot, selects bit3.
- R6: For a bus above the first and no greater than `cfg_end_bus`, the access forwards (bit2). `rt_port` is the lowest registered port index whose [`port_sec_bus`, `port_sub_bus`] range contains the bus. If no registered port's range contains the bus, or the bus lies above `cfg_end_bus`, the access selects bit3.
- R7: An access with `acc_addr[1:0]` ≠ 0 selects bit3.
- R8: `rt_rdata` is 0xFFFF_FFFF for an unroutable read and 0 otherwise. This includes unroutable writes, which are dropped.
- R9: Registering a root port (`reg_op` = 0) places it at device `cfg_first_dev` + ports already placed, with `rsp_status` OK (0). The response also carries:
  - `rsp_msi_devfn` = device << 3;
  - `rsp_hp_slot` = device + 1 if `reg_hotplug` is set, else 0.

  If that device would be 32 or more, or `NUM_PORTS` ports are already placed, the response is RANGE (3) with `rsp_dev` 0 and the table unchanged.
- R10: Registering an endpoint (`reg_op` = 1) into an empty slot `reg_dev` succeeds (OK). Registering one into an occupied slot returns BUSY (1) with `rsp_occupant` set to the occupant's identifier, and the table is unchanged.
- R11: Attaching a downstream device (`reg_op` = 2) to slot `reg_dev` behaves as follows:
  - an empty slot or an endpoint slot returns NOPORT (2);
  - a root port that already has a downstream device returns BUSY with that device's identifier;
  - otherwise the result is OK.

  `rsp_occupant` is 0 for any status other than BUSY.
- R12: `rsp_valid` follows `reg_valid` by exactly one cycle. `rsp_msi_devfn` and `rsp_hp_slot` are nonzero only for a successful root port placement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the slot table |
| cfg_start_bus | input | 8 | First bus owned by the complex |
| cfg_end_bus | input | 8 | Last bus owned by the complex |
| cfg_win_mib | input | 9 | Configured window size in MiB |
| cfg_first_dev | input | 5 | Device number of the first root port |
| cfg_err | output | 1 | Window size and bus range disagree |
| reg_valid | input | 1 | Registration request strobe |
| reg_op | input | 2 | 0 root port, 1 endpoint, 2 downstream device |
| reg_dev | input | 5 | Target device number for endpoint/downstream ops |
| reg_id | input | ID_W | Identifier of the item being registered |
| reg_hotplug | input | 1 | Root port is hotplug capable |
| rsp_valid | output | 1 | Registration response valid |
| rsp_status | output | 2 | 0 OK, 1 BUSY, 2 NOPORT, 3 RANGE |
| rsp_dev | output | 5 | Device number the request resolved to |
| rsp_msi_devfn | output | 8 | Interrupt requester devfn of a placed port |
| rsp_hp_slot | output | 6 | Hotplug slot number of a placed port |
| rsp_occupant | output | ID_W | Identifier of the conflicting occupant |
| port_sec_bus | input | NUM_PORTS*8 | Secondary bus of each root port |
| port_sub_bus | input | NUM_PORTS*8 | Subordinate bus of each root port |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 28 | Byte offset into the window |
| rt_valid | output | 1 | Routing result valid |
| rt_sel | output | 4 | One-hot target select |
| rt_bus | output | 8 | Decoded bus number |
| rt_devfn | output | 8 | Decoded device/function |
| rt_reg | output | 12 | Decoded register offset |
| rt_port | output | PIDX_W | Root port index for port-config or forward |
| rt_write | output | 1 | Registered write flag |
| rt_rdata | output | 32 | Fill data for unroutable reads |

## Verification
A corrupted slot kind shows up on the very next access to that device: the select moves between port, endpoint and unroutable, or a later registration reports a false conflict. A wrong port count shifts the device number returned by the next root port placement. It also lets an unregistered port's bus range catch forwarded traffic, so a bus that should be unroutable starts forwarding. Every one of these faults is visible on the first result after the fault, one cycle after the strobe, because nothing is buffered between the table and the outputs.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int BUS_W   = 8;
  localparam int DEVFN_W = 8;
  localparam int REG_W   = 12;
  localparam int FN_W    = 3;
  localparam int DEV_W   = DEVFN_W - FN_W;
  localparam int OFF_W   = BUS_W + DEVFN_W + REG_W;
  localparam int SLOTS   = 1 << DEV_W;
  localparam int SEL_W   = 4;

  localparam int SEL_PORT = 0;
  localparam int SEL_EP   = 1;
  localparam int SEL_FWD  = 2;
  localparam int SEL_UNR  = 3;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_PORT  = 2'd1,
    SLOT_EP    = 2'd2
  } slot_kind_e;

  localparam logic [1:0] OP_PORT = 2'd0;
  localparam logic [1:0] OP_EP   = 2'd1;
  localparam logic [1:0] OP_DS   = 2'd2;

  localparam logic [1:0] ST_OK     = 2'd0;
  localparam logic [1:0] ST_BUSY   = 2'd1;
  localparam logic [1:0] ST_NOPORT = 2'd2;
  localparam logic [1:0] ST_RANGE  = 2'd3;
endpackage

// File: rtl/ecam_addr_split.sv
module ecam_addr_split
  import ecam_pkg::*;
(
  input  logic [OFF_W-1:0]   off,
  input  logic [BUS_W-1:0]   start_bus,
  input  logic [BUS_W-1:0]   end_bus,
  output logic [BUS_W-1:0]   bus,
  output logic [DEVFN_W-1:0] devfn,
  output logic [REG_W-1:0]   regoff,
  output logic [DEV_W-1:0]   dev,
  output logic [FN_W-1:0]    fn,
  output logic               aligned,
  output logic               first_bus,
  output logic               in_range
);
  logic [BUS_W-1:0] rel;
  logic [BUS_W-1:0] span;

  always_comb begin
    rel       = off[OFF_W-1 -: BUS_W];
    span      = end_bus - start_bus;
    bus       = start_bus + rel;
    devfn     = off[REG_W +: DEVFN_W];
    regoff    = off[REG_W-1:0];
    dev       = devfn[DEVFN_W-1 -: DEV_W];
    fn        = devfn[FN_W-1:0];
    aligned   = (off[1:0] == 2'b00);
    first_bus = (rel == '0);
    in_range  = (end_bus >= start_bus) && (rel <= span);
  end
endmodule

// File: rtl/ecam_slot_table.sv
module ecam_slot_table
  import ecam_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ID_W      = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  first_dev,
  input  logic              reg_valid,
  input  logic [1:0]        reg_op,
  input  logic [DEV_W-1:0]  reg_dev,
  input  logic [ID_W-1:0]   reg_id,
  input  logic              reg_hotplug,
  input  logic [DEV_W-1:0]  lk_dev,
  output slot_kind_e        lk_kind,
  output logic [PIDX_W-1:0] lk_pidx,
  output logic [CNT_W-1:0]  port_cnt,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DEV_W-1:0]  rsp_dev,
  output logic [DEVFN_W-1:0] rsp_msi_devfn,
  output logic [DEV_W:0]    rsp_hp_slot,
  output logic [ID_W-1:0]   rsp_occupant
);
  slot_kind_e        kind_q [SLOTS];
  logic [ID_W-1:0]   id_q   [SLOTS];
  logic              ds_used_q [NUM_PORTS];
  logic [ID_W-1:0]   ds_id_q   [NUM_PORTS];
  logic [CNT_W-1:0]  cnt_q;

  logic              rsp_valid_q;
  logic [1:0]        rsp_status_q;
  logic [DEV_W-1:0]  rsp_dev_q;
  logic [DEVFN_W-1:0] rsp_msi_q;
  logic [DEV_W:0]    rsp_slot_q;
  logic [ID_W-1:0]   rsp_occ_q;

  logic [DEV_W:0]    new_dev;
  logic [DEV_W-1:0]  tgt_dev;
  slot_kind_e        occ_kind;
  logic [ID_W-1:0]   occ_id;
  logic [DEV_W:0]    ds_rel;
  logic [PIDX_W-1:0] ds_pidx;
  logic [DEV_W:0]    lk_rel;

  logic              tbl_we;
  slot_kind_e        tbl_kind;
  logic              ds_we;
  logic              cnt_inc;
  logic [1:0]        status_d;
  logic [DEV_W-1:0]  dev_d;
  logic [DEVFN_W-1:0] msi_d;
  logic [DEV_W:0]    slot_d;
  logic [ID_W-1:0]   occ_d;

  // lookup path for the access decoder
  always_comb begin
    lk_kind  = kind_q[lk_dev];
    lk_rel   = {1'b0, lk_dev} - {1'b0, first_dev};
    lk_pidx  = lk_rel[PIDX_W-1:0];
    port_cnt = cnt_q;
  end

  // registration next-state
  always_comb begin
    new_dev  = {1'b0, first_dev} + (DEV_W+1)'(cnt_q);
    tgt_dev  = (reg_op == OP_PORT) ? new_dev[DEV_W-1:0] : reg_dev;
    occ_kind = kind_q[tgt_dev];
    occ_id   = id_q[tgt_dev];
    ds_rel   = {1'b0, reg_dev} - {1'b0, first_dev};
    ds_pidx  = ds_rel[PIDX_W-1:0];

    tbl_we   = 1'b0;
    tbl_kind = SLOT_EMPTY;
    ds_we    = 1'b0;
    cnt_inc  = 1'b0;
    status_d = ST_NOPORT;
    dev_d    = tgt_dev;
    msi_d    = '0;
    slot_d   = '0;
    occ_d    = '0;

    unique case (reg_op)
      OP_PORT: begin
        if ((cnt_q == CNT_W'(NUM_PORTS)) || new_dev[DEV_W]) begin
          status_d = ST_RANGE;
          dev_d    = '0;
        end else if (occ_kind != SLOT_EMPTY) begin
          status_d = ST_BUSY;
          occ_d    = occ_id;
        end else begin
          status_d = ST_OK;
          tbl_we   = 1'b1;
          tbl_kind = SLOT_PORT;
          cnt_inc  = 1'b1;
          msi_d    = {new_dev[DEV_W-1:0], {FN_W{1'b0}}};
          slot_d   = reg_hotplug ? (new_dev + 1'b1) : '0;
        end
      end
      OP_EP: begin
        if (occ_kind != SLOT_EMPTY) begin
          status_d = ST_BUSY;
          occ_d    = occ_id;
        end else begin
          status_d = ST_OK;
          tbl_we   = 1'b1;
          tbl_kind = SLOT_EP;
        end
      end
      OP_DS: begin
        if (occ_kind != SLOT_PORT) begin
          status_d = ST_NOPORT;
        end else if (ds_used_q[ds_pidx]) begin
          status_d = ST_BUSY;
          occ_d    = ds_id_q[ds_pidx];
        end else begin
          status_d = ST_OK;
          ds_we    = 1'b1;
        end
      end
      default: status_d = ST_NOPORT;
    endcase

    if (!reg_valid) begin
      tbl_we  = 1'b0;
      ds_we   = 1'b0;
      cnt_inc = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        kind_q[i] <= SLOT_EMPTY;
        id_q[i]   <= '0;
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
        ds_used_q[p] <= 1'b0;
        ds_id_q[p]   <= '0;
      end
      cnt_q        <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= '0;
      rsp_dev_q    <= '0;
      rsp_msi_q    <= '0;
      rsp_slot_q   <= '0;
      rsp_occ_q    <= '0;
    end else begin
      if (tbl_we) begin
        kind_q[tgt_dev] <= tbl_kind;
        id_q[tgt_dev]   <= reg_id;
      end
      if (ds_we) begin
        ds_used_q[ds_pidx] <= 1'b1;
        ds_id_q[ds_pidx]   <= reg_id;
      end
      if (cnt_inc) begin
        cnt_q <= cnt_q + 1'b1;
      end
      rsp_valid_q <= reg_valid;
      if (reg_valid) begin
        rsp_status_q <= status_d;
        rsp_dev_q    <= dev_d;
        rsp_msi_q    <= msi_d;
        rsp_slot_q   <= slot_d;
        rsp_occ_q    <= occ_d;
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_status    = rsp_status_q;
  assign rsp_dev       = rsp_dev_q;
  assign rsp_msi_devfn = rsp_msi_q;
  assign rsp_hp_slot   = rsp_slot_q;
  assign rsp_occupant  = rsp_occ_q;
endmodule

// File: rtl/ecam_port_search.sv
module ecam_port_search
  import ecam_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic [BUS_W-1:0]           bus,
  input  logic [CNT_W-1:0]           port_cnt,
  input  logic [NUM_PORTS*BUS_W-1:0] sec_bus,
  input  logic [NUM_PORTS*BUS_W-1:0] sub_bus,
  output logic                       hit,
  output logic [PIDX_W-1:0]          hit_idx
);
  logic [NUM_PORTS-1:0] match;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_match
    logic [BUS_W-1:0] lo;
    logic [BUS_W-1:0] hi;
    assign lo = sec_bus[g*BUS_W +: BUS_W];
    assign hi = sub_bus[g*BUS_W +: BUS_W];
    assign match[g] = (CNT_W'(g) < port_cnt) && (bus >= lo) && (bus <= hi);
  end

  // lowest index wins: walk from the top so the last hit assigned is the lowest
  always_comb begin
    hit     = |match;
    hit_idx = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx = PIDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ecam_cfg_router.sv
module ecam_cfg_router
  import ecam_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ID_W      = 8,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CNT_W    = $clog2(NUM_PORTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 cfg_start_bus,
  input  logic [7:0]                 cfg_end_bus,
  input  logic [8:0]                 cfg_win_mib,
  input  logic [4:0]                 cfg_first_dev,
  output logic                       cfg_err,
  input  logic                       reg_valid,
  input  logic [1:0]                 reg_op,
  input  logic [4:0]                 reg_dev,
  input  logic [ID_W-1:0]            reg_id,
  input  logic                       reg_hotplug,
  output logic                       rsp_valid,
  output logic [1:0]                 rsp_status,
  output logic [4:0]                 rsp_dev,
  output logic [7:0]                 rsp_msi_devfn,
  output logic [5:0]                 rsp_hp_slot,
  output logic [ID_W-1:0]            rsp_occupant,
  input  logic [NUM_PORTS*8-1:0]     port_sec_bus,
  input  logic [NUM_PORTS*8-1:0]     port_sub_bus,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [27:0]                acc_addr,
  output logic                       rt_valid,
  output logic [3:0]                 rt_sel,
  output logic [7:0]                 rt_bus,
  output logic [7:0]                 rt_devfn,
  output logic [11:0]                rt_reg,
  output logic [PIDX_W-1:0]          rt_port,
  output logic                       rt_write,
  output logic [31:0]                rt_rdata
);
  logic [BUS_W-1:0]   a_bus;
  logic [DEVFN_W-1:0] a_devfn;
  logic [REG_W-1:0]   a_reg;
  logic [DEV_W-1:0]   a_dev;
  logic [FN_W-1:0]    a_fn;
  logic               a_aligned;
  logic               a_first;
  logic               a_in_range;

  slot_kind_e         lk_kind;
  logic [PIDX_W-1:0]  lk_pidx;
  logic [CNT_W-1:0]   port_cnt;
  logic               s_hit;
  logic [PIDX_W-1:0]  s_idx;

  logic [SEL_W-1:0]   sel_n;
  logic [PIDX_W-1:0]  port_n;
  logic [SEL_W-1:0]   sel_d;
  logic [31:0]        rdata_d;

  logic               valid_q;
  logic [SEL_W-1:0]   sel_q;
  logic [BUS_W-1:0]   bus_q;
  logic [DEVFN_W-1:0] devfn_q;
  logic [REG_W-1:0]   reg_q;
  logic [PIDX_W-1:0]  port_q;
  logic               write_q;
  logic [31:0]        rdata_q;

  ecam_addr_split u_split (
    .off       (acc_addr),
    .start_bus (cfg_start_bus),
    .end_bus   (cfg_end_bus),
    .bus       (a_bus),
    .devfn     (a_devfn),
    .regoff    (a_reg),
    .dev       (a_dev),
    .fn        (a_fn),
    .aligned   (a_aligned),
    .first_bus (a_first),
    .in_range  (a_in_range)
  );

  ecam_slot_table #(.NUM_PORTS(NUM_PORTS), .ID_W(ID_W)) u_table (
    .clk           (clk),
    .rst_n         (rst_n),
    .first_dev     (cfg_first_dev),
    .reg_valid     (reg_valid),
    .reg_op        (reg_op),
    .reg_dev       (reg_dev),
    .reg_id        (reg_id),
    .reg_hotplug   (reg_hotplug),
    .lk_dev        (a_dev),
    .lk_kind       (lk_kind),
    .lk_pidx       (lk_pidx),
    .port_cnt      (port_cnt),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_dev       (rsp_dev),
    .rsp_msi_devfn (rsp_msi_devfn),
    .rsp_hp_slot   (rsp_hp_slot),
    .rsp_occupant  (rsp_occupant)
  );

  ecam_port_search #(.NUM_PORTS(NUM_PORTS)) u_search (
    .bus      (a_bus),
    .port_cnt (port_cnt),
    .sec_bus  (port_sec_bus),
    .sub_bus  (port_sub_bus),
    .hit      (s_hit),
    .hit_idx  (s_idx)
  );

  // window size versus bus range
  always_comb begin
    cfg_err = (cfg_end_bus < cfg_start_bus) ||
              (cfg_win_mib != ({1'b0, cfg_end_bus} - {1'b0, cfg_start_bus} + 9'd1));
  end

  // target selection
  always_comb begin
    sel_n  = '0;
    port_n = '0;
    if (!a_aligned || !a_in_range) begin
      sel_n[SEL_UNR] = 1'b1;
    end else if (a_first) begin
      if ((a_fn == '0) && (lk_kind == SLOT_PORT)) begin
        sel_n[SEL_PORT] = 1'b1;
        port_n          = lk_pidx;
      end else if ((a_fn == '0) && (lk_kind == SLOT_EP)) begin
        sel_n[SEL_EP] = 1'b1;
      end else begin
        sel_n[SEL_UNR] = 1'b1;
      end
    end else if (s_hit) begin
      sel_n[SEL_FWD] = 1'b1;
      port_n         = s_idx;
    end else begin
      sel_n[SEL_UNR] = 1'b1;
    end

    sel_d   = acc_valid ? sel_n : '0;
    rdata_d = (acc_valid && sel_n[SEL_UNR] && !acc_write) ? 32'hFFFF_FFFF : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
      bus_q   <= '0;
      devfn_q <= '0;
      reg_q   <= '0;
      port_q  <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= acc_valid;
      sel_q   <= sel_d;
      rdata_q <= rdata_d;
      if (acc_valid) begin
        bus_q   <= a_bus;
        devfn_q <= a_devfn;
        reg_q   <= a_reg;
        port_q  <= port_n;
        write_q <= acc_write;
      end
    end
  end

  assign rt_valid = valid_q;
  assign rt_sel   = sel_q;
  assign rt_bus   = bus_q;
  assign rt_devfn = devfn_q;
  assign rt_reg   = reg_q;
  assign rt_port  = port_q;
  assign rt_write = write_q;
  assign rt_rdata = rdata_q;
endmodule

// File: rtl/ecam_cfg_router_chk.sv
module ecam_cfg_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  cfg_start_bus,
  input logic        acc_valid,
  input logic [27:0] acc_addr,
  input logic        reg_valid,
  input logic [1:0]  reg_op,
  input logic        rt_valid,
  input logic [3:0]  rt_sel,
  input logic [7:0]  rt_bus,
  input logic [7:0]  rt_devfn,
  input logic        rt_write,
  input logic [31:0] rt_rdata,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic [4:0]  rsp_dev,
  input logic [7:0]  rsp_msi_devfn,
  input logic [5:0]  rsp_hp_slot
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $countones(rt_sel) == 1); // R2
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_valid |-> rt_sel == 4'b0); // R2
  AST_ACC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rt_valid); // R2
  AST_PORT_FN0: assert property (@(posedge clk) disable iff (!rst_n)
    rt_sel[0] |-> (rt_devfn[2:0] == 3'd0) && (rt_bus == cfg_start_bus)); // R3
  AST_EP_FN0: assert property (@(posedge clk) disable iff (!rst_n)
    rt_sel[1] |-> (rt_devfn[2:0] == 3'd0) && (rt_bus == cfg_start_bus)); // R4
  AST_FWD_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    rt_sel[2] |-> rt_bus != cfg_start_bus); // R6
  AST_MISALIGN_UNR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_addr[1:0] != 2'b00)) |=> rt_sel[3]); // R7
  AST_UNR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel[3] && !rt_write) |-> rt_rdata == 32'hFFFF_FFFF); // R8
  AST_FILL_ONLY_UNR: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_sel[3] && !rt_write) |-> rt_rdata == 32'h0); // R8
  AST_MSI_DEVFN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd0 && $past(reg_op) == 2'd0)
      |-> rsp_msi_devfn == {rsp_dev, 3'b000}); // R9
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |=> rsp_valid); // R12
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_valid |=> !rsp_valid); // R12
  AST_HP_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_hp_slot == 6'd0) && (rsp_msi_devfn == 8'd0)); // R12
endmodule

bind ecam_cfg_router ecam_cfg_router_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_start_bus (cfg_start_bus),
  .acc_valid     (acc_valid),
  .acc_addr      (acc_addr),
  .reg_valid     (reg_valid),
  .reg_op        (reg_op),
  .rt_valid      (rt_valid),
  .rt_sel        (rt_sel),
  .rt_bus        (rt_bus),
  .rt_devfn      (rt_devfn),
  .rt_write      (rt_write),
  .rt_rdata      (rt_rdata),
  .rsp_valid     (rsp_valid),
  .rsp_status    (rsp_status),
  .rsp_dev       (rsp_dev),
  .rsp_msi_devfn (rsp_msi_devfn),
  .rsp_hp_slot   (rsp_hp_slot)
);

// File: tb/ecam_cfg_router_tb.sv
module ecam_cfg_router_tb;
  localparam int NP = 4;
  localparam int PW = 2;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_start_bus;
  logic [7:0]  cfg_end_bus;
  logic [8:0]  cfg_win_mib;
  logic [4:0]  cfg_first_dev;
  logic        cfg_err;
  logic        reg_valid;
  logic [1:0]  reg_op;
  logic [4:0]  reg_dev;
  logic [7:0]  reg_id;
  logic        reg_hotplug;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [4:0]  rsp_dev;
  logic [7:0]  rsp_msi_devfn;
  logic [5:0]  rsp_hp_slot;
  logic [7:0]  rsp_occupant;
  logic [NP*8-1:0] port_sec_bus;
  logic [NP*8-1:0] port_sub_bus;
  logic        acc_valid;
  logic        acc_write;
  logic [27:0] acc_addr;
  logic        rt_valid;
  logic [3:0]  rt_sel;
  logic [7:0]  rt_bus;
  logic [7:0]  rt_devfn;
  logic [11:0] rt_reg;
  logic [PW-1:0] rt_port;
  logic        rt_write;
  logic [31:0] rt_rdata;

  int n_tests;
  int n_fail;

  ecam_cfg_router #(.NUM_PORTS(NP), .ID_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start_bus(cfg_start_bus), .cfg_end_bus(cfg_end_bus),
    .cfg_win_mib(cfg_win_mib), .cfg_first_dev(cfg_first_dev), .cfg_err(cfg_err),
    .reg_valid(reg_valid), .reg_op(reg_op), .reg_dev(reg_dev), .reg_id(reg_id),
    .reg_hotplug(reg_hotplug), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
    .rsp_dev(rsp_dev), .rsp_msi_devfn(rsp_msi_devfn), .rsp_hp_slot(rsp_hp_slot),
    .rsp_occupant(rsp_occupant), .port_sec_bus(port_sec_bus), .port_sub_bus(port_sub_bus),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .rt_valid(rt_valid), .rt_sel(rt_sel), .rt_bus(rt_bus), .rt_devfn(rt_devfn),
    .rt_reg(rt_reg), .rt_port(rt_port), .rt_write(rt_write), .rt_rdata(rt_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic        wr;
    logic [27:0] off;
    logic [3:0]  sel;
    logic [1:0]  port;
  } vec_t;

  // sel: 1 port cfg, 2 endpoint, 4 forward, 8 unroutable
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 28'h0010010, 4'b0001, 2'd0},  // dev2 fn0 -> port0 (R3)
    '{1'b0, 28'h0020100, 4'b0001, 2'd2},  // dev4 fn0 -> port2 (R3)
    '{1'b0, 28'h0018000, 4'b0001, 2'd1},  // dev3 fn0 still port after rejected endpoint (R10)
    '{1'b0, 28'h0000004, 4'b0010, 2'd0},  // dev0 endpoint (R4)
    '{1'b0, 28'h0011000, 4'b1000, 2'd0},  // dev2 fn1 (R5)
    '{1'b0, 28'h0008000, 4'b1000, 2'd0},  // dev1 empty (R5)
    '{1'b0, 28'h0105040, 4'b0100, 2'd0},  // bus3 -> port0 (R6)
    '{1'b0, 28'h0300000, 4'b0100, 2'd0},  // bus5 overlap -> lowest port0 (R6)
    '{1'b1, 28'h0400000, 4'b0100, 2'd1},  // bus6 write -> port1 (R6)
    '{1'b0, 28'h0600008, 4'b0100, 2'd2},  // bus8 -> port2 (R6)
    '{1'b0, 28'h0700000, 4'b1000, 2'd0},  // bus9 only in unregistered port3 (R6)
    '{1'b0, 28'h0800000, 4'b1000, 2'd0},  // bus10 above end (R6)
    '{1'b0, 28'h0010011, 4'b1000, 2'd0},  // misaligned (R7)
    '{1'b1, 28'h0008000, 4'b1000, 2'd0}   // unroutable write dropped (R8)
  };

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_reg(input logic [1:0] op, input logic [4:0] dev, input logic [7:0] id,
                        input logic hp, input logic [1:0] e_st, input logic [4:0] e_dev,
                        input logic [7:0] e_msi, input logic [5:0] e_slot,
                        input logic [7:0] e_occ, input string req);
    logic [28:0] act;
    logic [28:0] exp;
    @(negedge clk);
    reg_valid = 1'b1; reg_op = op; reg_dev = dev; reg_id = id; reg_hotplug = hp;
    @(negedge clk);
    reg_valid = 1'b0;
    act = {rsp_status, rsp_dev, rsp_msi_devfn, rsp_hp_slot, rsp_occupant};
    exp = {e_st, e_dev, e_msi, e_slot, e_occ};
    check(rsp_valid && (act == exp), req, "registration response",
          {2'b0, act}, {2'b0, exp});
  endtask

  task automatic do_acc(input logic wr, input logic [27:0] off, input logic [3:0] e_sel,
                        input logic [1:0] e_port, input string req);
    logic [7:0]  e_bus;
    logic [31:0] e_rd;
    e_bus = cfg_start_bus + off[27:20];
    e_rd  = (e_sel == 4'b1000 && !wr) ? 32'hFFFF_FFFF : 32'h0;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = off;
    @(negedge clk);
    acc_valid = 1'b0;
    check(rt_valid && rt_sel == e_sel, req, "select", {27'b0, rt_valid, rt_sel}, {28'h1, e_sel});
    check(rt_bus == e_bus && rt_devfn == off[19:12] && rt_reg == off[11:0], "R2", "fields",
          {4'b0, rt_bus, rt_devfn, rt_reg}, {4'b0, e_bus, off[19:12], off[11:0]});
    check(rt_rdata == e_rd, "R8", "fill data", rt_rdata, e_rd);
    if (e_sel == 4'b0001 || e_sel == 4'b0100)
      check(rt_port == e_port, req, "port index", {30'b0, rt_port}, {30'b0, e_port});
  endtask

  task automatic cfg_case(input logic [7:0] s, input logic [7:0] e, input logic [8:0] w,
                          input logic exp);
    cfg_start_bus = s; cfg_end_bus = e; cfg_win_mib = w;
    #1;
    check(cfg_err == exp, "R1", "window check", {31'b0, cfg_err}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0;
    reg_valid = 1'b0; reg_op = 2'd0; reg_dev = 5'd0; reg_id = 8'd0; reg_hotplug = 1'b0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 28'd0;
    cfg_first_dev = 5'd2;
    port_sec_bus = {8'd9, 8'd8, 8'd5, 8'd3};
    port_sub_bus = {8'd9, 8'd8, 8'd7, 8'd5};

    // R1 window size
    cfg_case(8'd0, 8'd0, 9'd1, 1'b0);
    cfg_case(8'd0, 8'd0, 9'd2, 1'b1);
    cfg_case(8'd0, 8'd255, 9'd256, 1'b0);
    cfg_case(8'd9, 8'd2, 9'd8, 1'b1);
    cfg_case(8'd2, 8'd9, 9'd8, 1'b0);

    // reset state
    repeat (2) @(negedge clk);
    check(!rt_valid && rt_sel == 4'b0, "R2", "reset result idle", {27'b0, rt_valid, rt_sel}, 32'h0);
    check(!rsp_valid, "R12", "reset response idle", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;

    // registrations: status 0 OK, 1 BUSY, 2 NOPORT, 3 RANGE
    do_reg(2'd1, 5'd0, 8'hA0, 1'b0, 2'd0, 5'd0, 8'h00, 6'd0, 8'h00, "R10");
    do_reg(2'd1, 5'd0, 8'hA1, 1'b0, 2'd1, 5'd0, 8'h00, 6'd0, 8'hA0, "R10");
    do_reg(2'd0, 5'd0, 8'h10, 1'b1, 2'd0, 5'd2, 8'h10, 6'd3, 8'h00, "R9");
    do_reg(2'd0, 5'd0, 8'h11, 1'b0, 2'd0, 5'd3, 8'h18, 6'd0, 8'h00, "R9");
    do_reg(2'd0, 5'd0, 8'h12, 1'b1, 2'd0, 5'd4, 8'h20, 6'd5, 8'h00, "R9");
    do_reg(2'd1, 5'd3, 8'hB0, 1'b0, 2'd1, 5'd3, 8'h00, 6'd0, 8'h11, "R10");
    do_reg(2'd2, 5'd1, 8'h50, 1'b0, 2'd2, 5'd1, 8'h00, 6'd0, 8'h00, "R11");
    do_reg(2'd2, 5'd0, 8'h51, 1'b0, 2'd2, 5'd0, 8'h00, 6'd0, 8'h00, "R11");
    do_reg(2'd2, 5'd3, 8'h55, 1'b0, 2'd0, 5'd3, 8'h00, 6'd0, 8'h00, "R11");
    do_reg(2'd2, 5'd3, 8'h56, 1'b0, 2'd1, 5'd3, 8'h00, 6'd0, 8'h55, "R11");

    // table-driven access decode
    for (int i = 0; i < NV; i++) begin
      do_acc(VECS[i].wr, VECS[i].off, VECS[i].sel, VECS[i].port, "R3/R4/R5/R6/R7");
    end

    // reset clears the table: former port slot now unroutable
    do_reset();
    do_acc(1'b0, 28'h0010000, 4'b1000, 2'd0, "R5");

    // port count limit
    cfg_first_dev = 5'd0;
    for (int k = 0; k < NP; k++) begin
      do_reg(2'd0, 5'd0, 8'(8'h20 + k), 1'b0, 2'd0, 5'(k), 8'(k * 8), 6'd0, 8'h00, "R9");
    end
    do_reg(2'd0, 5'd0, 8'h2F, 1'b1, 2'd3, 5'd0, 8'h00, 6'd0, 8'h00, "R9");

    // device number limit at the top of the bus
    do_reset();
    cfg_first_dev = 5'd30;
    do_reg(2'd0, 5'd0, 8'h30, 1'b0, 2'd0, 5'd30, 8'hF0, 6'd0, 8'h00, "R9");
    do_reg(2'd0, 5'd0, 8'h31, 1'b1, 2'd0, 5'd31, 8'hF8, 6'd32, 8'h00, "R9");
    do_reg(2'd0, 5'd0, 8'h32, 1'b1, 2'd3, 5'd0, 8'h00, 6'd0, 8'h00, "R9");
    do_acc(1'b0, 28'h00F8000, 4'b0001, 2'd1, "R3");
    do_acc(1'b1, 28'h00F9000, 4'b1000, 2'd0, "R5");

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule